// File: doc/BRIEF.md
# TLB Access-Rights and Fault Checker

This block sits after the translation lookup of a memory access path. It receives the entry the lookup returned (hit flag, a 3-bit rights type, a read bound and a write bound in privilege levels, an access identifier and the dirty, break and reference-trap bits). It also receives the privilege level of the requester, a protection-check enable, a bank of protection-id registers and the kind of access being made. From these it forms the permission set the entry grants and one fault code chosen by a fixed priority.

Level 0 is the most privileged level. The permission set is first derived from the rights type and the two bounds. It is then narrowed in two steps. The first is a write-disable taken from a protection-id match. The second is the dirty, break and reference conditions. A debug access kind skips every fault check and only reports the permission set. Permission and fault are both registered, so they appear one clock after the inputs are sampled.

Top module: `tlb_perm_checker`

## Requirements
- R1: While `rst_n` is low, `grant_perm` and `fault_code` are 0. Otherwise both show the result for the inputs sampled at the previous rising clock edge.
- R2: `grant_perm` bit 0 is read, bit 1 is write and bit 2 is execute. Read is available when `cur_priv` <= `entry_rd_pl`. Write is available when `cur_priv` <= `entry_wr_pl`.
- R3: Execute is available only when `entry_wr_pl` <= `cur_priv` <= `entry_rd_pl`.
- R4: For `entry_type`, 0 gives read, 1 gives read/write, 2 gives read/execute and 3 gives read/write/execute. Values 4 to 7 give execute only. Each right is further gated by R2 and R3.
- R5: `req_kind` is coded 0 = debug, 1 = read, 2 = write, 3 = execute. When `entry_hit` is low, `grant_perm` is 0. `fault_code` is then 1 for an execute and 2 for any other kind.
- R6: The protection-id rule applies only when `pid_check_en` is 1 and `entry_aid` is nonzero. If the value `entry_aid`*2+1 equals any slot of `pid_bank`, write is removed from `grant_perm`. In that case a write gets `fault_code` 3.
- R7: A read, write or execute whose right is absent from the permission set gets `fault_code` 4 for an execute and 5 otherwise.
- R8: If no earlier fault applies, the entry bits are checked in this order. A set `entry_trap` on a read or write gives 8. Otherwise, a set `entry_break` on a write gives 7. Otherwise, a clear `entry_dirty` on a write gives 6.
- R9: When R8 is evaluated, a clear dirty bit or a set break bit removes write from `grant_perm` even without a fault. A set trap bit leaves only execute.
- R10: With `req_kind` 0 on a hit, `fault_code` is 0. `grant_perm` is then the R4 set after the R6 write removal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_hit | input | 1 | Lookup found an entry |
| entry_type | input | 3 | Rights type of the entry |
| entry_rd_pl | input | PL_W | Least privileged level allowed to read |
| entry_wr_pl | input | PL_W | Least privileged level allowed to write |
| entry_aid | input | AID_W | Access identifier, 0 = public |
| entry_dirty | input | 1 | Page already written |
| entry_break | input | 1 | Break on write |
| entry_trap | input | 1 | Trap on data reference |
| cur_priv | input | PL_W | Requester privilege level |
| pid_check_en | input | 1 | Enable protection-id check |
| pid_bank | input | NUM_PID*(AID_W+1) | Protection-id registers, slot i at bits i*(AID_W+1) upward |
| req_kind | input | 2 | Access kind |
| grant_perm | output | 3 | Registered permission set |
| fault_code | output | 4 | Registered fault code |

## Verification
The hardest situation to reach from the ports is a fault lower in the order masked by a higher one. Examples are a write that trips both the trap and the break bit while the dirty bit is clear, or a protection-id match together with a clear dirty bit. The directed tasks build entries whose rights and privilege checks pass, so control reaches the entry-bit stage. They then stack the conditions so that only the priority decides the code. A debug kind is also applied to entries that would fault. This shows that narrowing by the trap bit is not applied in that mode.

// File: rtl/tlb_chk_pkg.sv
package tlb_chk_pkg;

  typedef enum logic [1:0] {
    KIND_DEBUG = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_EXEC  = 2'd3
  } kind_e;

  typedef enum logic [3:0] {
    FLT_NONE    = 4'd0,
    FLT_IMISS   = 4'd1,
    FLT_DMISS   = 4'd2,
    FLT_PID     = 4'd3,
    FLT_IPROT   = 4'd4,
    FLT_DRIGHTS = 4'd5,
    FLT_DIRTY   = 4'd6,
    FLT_BREAK   = 4'd7,
    FLT_REF     = 4'd8
  } fault_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

  // rights granted by the type field, before privilege gating
  function automatic logic [2:0] type_rights(input logic [2:0] ty);
    case (ty)
      3'd0:    return 3'b001;
      3'd1:    return 3'b011;
      3'd2:    return 3'b101;
      3'd3:    return 3'b111;
      default: return 3'b100;
    endcase
  endfunction

  // one-hot mask of the permission a given access kind needs
  function automatic logic [2:0] kind_need(input kind_e k);
    case (k)
      KIND_READ:  return 3'b001;
      KIND_WRITE: return 3'b010;
      KIND_EXEC:  return 3'b100;
      default:    return 3'b000;
    endcase
  endfunction

  function automatic fault_e miss_fault(input kind_e k);
    return (k == KIND_EXEC) ? FLT_IMISS : FLT_DMISS;
  endfunction

endpackage

// File: rtl/tlb_rights_decode.sv
module tlb_rights_decode #(
  parameter int PL_W = 2
) (
  input  logic [2:0]      ty,
  input  logic [PL_W-1:0] rd_pl,
  input  logic [PL_W-1:0] wr_pl,
  input  logic [PL_W-1:0] cur,
  output logic [2:0]      perm
);
  import tlb_chk_pkg::*;

  logic rd_ok, wr_ok, x_ok;
  logic [2:0] gate;

  always_comb begin
    rd_ok = (cur <= rd_pl);
    wr_ok = (cur <= wr_pl);
    x_ok  = (wr_pl <= cur) && (cur <= rd_pl);
    gate  = {x_ok, wr_ok, rd_ok};
    perm  = type_rights(ty) & gate;
  end

  always_comb begin
    if (perm[PERM_X]) begin
      AST_EXEC_WINDOW: assert ((cur <= rd_pl) && (cur >= wr_pl)); // R3
    end
    if (perm[PERM_W]) begin
      AST_WRITE_TYPE: assert (ty == 3'd1 || ty == 3'd3); // R4
    end
  end

endmodule

// File: rtl/tlb_pid_match.sv
module tlb_pid_match #(
  parameter int AID_W   = 18,
  parameter int NUM_PID = 4,
  localparam int PIDW   = AID_W + 1
) (
  input  logic                    en,
  input  logic [AID_W-1:0]        aid,
  input  logic [NUM_PID*PIDW-1:0] bank,
  output logic                    wr_disable
);
  logic [PIDW-1:0]    probe;
  logic [NUM_PID-1:0] slot_eq;

  assign probe = {aid, 1'b1};

  for (genvar i = 0; i < NUM_PID; i++) begin : g_slot
    assign slot_eq[i] = (bank[i*PIDW +: PIDW] == probe);
  end

  assign wr_disable = en && (|aid) && (|slot_eq);

endmodule

// File: rtl/tlb_fault_resolve.sv
module tlb_fault_resolve (
  input  logic                 hit,
  input  tlb_chk_pkg::kind_e   kind,
  input  logic [2:0]           base_perm,
  input  logic                 pid_block,
  input  logic                 dirty,
  input  logic                 brk,
  input  logic                 trap,
  output logic [2:0]           perm,
  output tlb_chk_pkg::fault_e  fault,
  output logic                 bits_stage
);
  import tlb_chk_pkg::*;

  always_comb begin
    perm       = base_perm;
    fault      = FLT_NONE;
    bits_stage = 1'b0;
    if (!hit) begin
      perm  = 3'b000;
      fault = miss_fault(kind);
    end else begin
      if (pid_block) perm[PERM_W] = 1'b0;
      if (pid_block && kind == KIND_WRITE) begin
        fault = FLT_PID;
      end else if (kind != KIND_DEBUG) begin
        if ((perm & kind_need(kind)) == 3'b000) begin
          fault = (kind == KIND_EXEC) ? FLT_IPROT : FLT_DRIGHTS;
        end else begin
          bits_stage = 1'b1;
          // lowest priority first, later assignments override
          if (!dirty) begin
            if (kind == KIND_WRITE) fault = FLT_DIRTY;
            perm[PERM_W] = 1'b0;
          end
          if (brk) begin
            if (kind == KIND_WRITE) fault = FLT_BREAK;
            perm[PERM_W] = 1'b0;
          end
          if (trap) begin
            if (kind != KIND_EXEC) fault = FLT_REF;
            perm = perm & 3'b100;
          end
        end
      end
    end
  end

endmodule

// File: rtl/tlb_perm_checker.sv
module tlb_perm_checker #(
  parameter int PL_W    = 2,
  parameter int AID_W   = 18,
  parameter int NUM_PID = 4,
  localparam int PIDW   = AID_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    entry_hit,
  input  logic [2:0]              entry_type,
  input  logic [PL_W-1:0]         entry_rd_pl,
  input  logic [PL_W-1:0]         entry_wr_pl,
  input  logic [AID_W-1:0]        entry_aid,
  input  logic                    entry_dirty,
  input  logic                    entry_break,
  input  logic                    entry_trap,
  input  logic [PL_W-1:0]         cur_priv,
  input  logic                    pid_check_en,
  input  logic [NUM_PID*PIDW-1:0] pid_bank,
  input  logic [1:0]              req_kind,
  output logic [2:0]              grant_perm,
  output logic [3:0]              fault_code
);
  import tlb_chk_pkg::*;

  kind_e      kind;
  logic [2:0] base_perm;
  logic       pid_block;
  logic [2:0] perm_d;
  fault_e     fault_d;
  logic       bits_stage;

  assign kind = kind_e'(req_kind);

  tlb_rights_decode #(.PL_W(PL_W)) u_rights (
    .ty    (entry_type),
    .rd_pl (entry_rd_pl),
    .wr_pl (entry_wr_pl),
    .cur   (cur_priv),
    .perm  (base_perm)
  );

  tlb_pid_match #(.AID_W(AID_W), .NUM_PID(NUM_PID)) u_pid (
    .en         (pid_check_en),
    .aid        (entry_aid),
    .bank       (pid_bank),
    .wr_disable (pid_block)
  );

  tlb_fault_resolve u_resolve (
    .hit        (entry_hit),
    .kind       (kind),
    .base_perm  (base_perm),
    .pid_block  (pid_block),
    .dirty      (entry_dirty),
    .brk        (entry_break),
    .trap       (entry_trap),
    .perm       (perm_d),
    .fault      (fault_d),
    .bits_stage (bits_stage)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_perm <= 3'b000;
      fault_code <= 4'd0;
    end else begin
      grant_perm <= perm_d;
      fault_code <= fault_d;
    end
  end

  AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !entry_hit |-> (perm_d == 3'b000 && (fault_d == FLT_IMISS || fault_d == FLT_DMISS))); // R5

  AST_PID_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_hit && pid_block) |-> !perm_d[PERM_W]); // R6

  AST_TRAP_EXEC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bits_stage && entry_trap) |-> (perm_d[PERM_R] == 1'b0 && perm_d[PERM_W] == 1'b0)); // R9

  AST_DEBUG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_hit && kind == KIND_DEBUG) |-> fault_d == FLT_NONE); // R10

  AST_PERM_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_d & ~base_perm) == 3'b000); // R4

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (grant_perm == 3'b000 && fault_code == 4'd0)); // R1

  AST_TRAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (bits_stage && entry_trap && kind != KIND_EXEC) |-> fault_d == FLT_REF); // R8

endmodule

// File: tb/tlb_perm_checker_tb.sv
module tlb_perm_checker_tb_top;
  localparam int PL_W = 2;
  localparam int AID_W = 18;
  localparam int NUM_PID = 4;
  localparam int PIDW = AID_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hit = 1'b0;
  logic [2:0] ty = '0;
  logic [PL_W-1:0] rd_pl = '0, wr_pl = '0, cur = '0;
  logic [AID_W-1:0] aid = '0;
  logic dirty = 1'b1, brk = 1'b0, trap = 1'b0, pen = 1'b0;
  logic [NUM_PID*PIDW-1:0] bank = '0;
  logic [1:0] kind = 2'd0;
  logic [2:0] perm;
  logic [3:0] fault;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tlb_perm_checker #(.PL_W(PL_W), .AID_W(AID_W), .NUM_PID(NUM_PID)) dut_i (
    .clk(clk), .rst_n(rst_n), .entry_hit(hit), .entry_type(ty),
    .entry_rd_pl(rd_pl), .entry_wr_pl(wr_pl), .entry_aid(aid),
    .entry_dirty(dirty), .entry_break(brk), .entry_trap(trap),
    .cur_priv(cur), .pid_check_en(pen), .pid_bank(bank),
    .req_kind(kind), .grant_perm(perm), .fault_code(fault)
  );

  task automatic compare(input logic [2:0] ep, input logic [3:0] ef, input string tag);
    checks++;
    if (perm !== ep || fault !== ef) begin
      fails++;
      $display("FAIL %s: perm=%0d fault=%0d expected perm=%0d fault=%0d", tag, perm, fault, ep, ef);
    end
  endtask

  task automatic run(input logic [2:0] ep, input logic [3:0] ef, input string tag);
    @(posedge clk);
    @(negedge clk);
    compare(ep, ef, tag);
  endtask

  // standard entry: rights pass for cur=1 under type 3
  task automatic base_entry();
    hit = 1'b1; ty = 3'd3; rd_pl = 2'd2; wr_pl = 2'd1; cur = 2'd1;
    aid = '0; dirty = 1'b1; brk = 1'b0; trap = 1'b0; pen = 1'b0; bank = '0;
  endtask

  task automatic t_reset();
    hit = 1'b0; kind = 2'd3;
    repeat (2) @(posedge clk);
    @(negedge clk);
    compare(3'd0, 4'd0, "R1 reset");
    rst_n = 1'b1;
    compare(3'd0, 4'd0, "R1 held before edge");
    run(3'd0, 4'd1, "R1 one-cycle latency");
  endtask

  task automatic t_miss();
    @(negedge clk); hit = 1'b0; kind = 2'd3; run(3'd0, 4'd1, "R5 exec miss");
    kind = 2'd1; run(3'd0, 4'd2, "R5 read miss");
    kind = 2'd0; run(3'd0, 4'd2, "R5 debug miss");
  endtask

  task automatic t_priv();
    base_entry(); kind = 2'd0;
    cur = 2'd0; run(3'b011, 4'd0, "R2 level0 rw no exec R3");
    cur = 2'd1; run(3'b111, 4'd0, "R3 inside window");
    cur = 2'd2; run(3'b101, 4'd0, "R2 level2 no write");
    cur = 2'd3; run(3'b000, 4'd0, "R2 level3 nothing");
  endtask

  task automatic t_types();
    logic [2:0] exp_p [8];
    exp_p = '{3'b001, 3'b011, 3'b101, 3'b111, 3'b100, 3'b100, 3'b100, 3'b100};
    base_entry(); kind = 2'd0;
    for (int i = 0; i < 8; i++) begin
      ty = 3'(i);
      run(exp_p[i], 4'd0, $sformatf("R4 type %0d", i));
    end
  endtask

  task automatic t_rights();
    base_entry();
    ty = 3'd0; kind = 2'd2; run(3'b001, 4'd5, "R7 write on read-only");
    ty = 3'd4; kind = 2'd1; run(3'b100, 4'd5, "R7 read on exec-only");
    ty = 3'd0; kind = 2'd3; run(3'b001, 4'd4, "R7 exec on read-only");
  endtask

  task automatic t_pid();
    base_entry(); pen = 1'b1; aid = 18'd5;
    bank[2*PIDW +: PIDW] = 19'd11;
    kind = 2'd2; run(3'b101, 4'd3, "R6 write match");
    dirty = 1'b0; run(3'b101, 4'd3, "R6 pid beats dirty R8");
    dirty = 1'b1; kind = 2'd1; run(3'b101, 4'd0, "R6 read match");
    kind = 2'd2; pen = 1'b0; run(3'b111, 4'd0, "R6 disabled");
    pen = 1'b1; bank[2*PIDW +: PIDW] = 19'd10; run(3'b111, 4'd0, "R6 even value");
    aid = '0; bank[0 +: PIDW] = 19'd1; run(3'b111, 4'd0, "R6 public id");
  endtask

  task automatic t_bits();
    base_entry();
    kind = 2'd2; dirty = 1'b0; run(3'b101, 4'd6, "R8 dirty write");
    kind = 2'd1; run(3'b101, 4'd0, "R9 dirty read trims write");
    kind = 2'd2; brk = 1'b1; run(3'b101, 4'd7, "R8 break over dirty");
    dirty = 1'b1; kind = 2'd1; run(3'b101, 4'd0, "R9 break read trims write");
    brk = 1'b0; trap = 1'b1; run(3'b100, 4'd8, "R8 trap read R9");
    kind = 2'd2; brk = 1'b1; dirty = 1'b0; run(3'b100, 4'd8, "R8 trap over break");
    kind = 2'd3; brk = 1'b0; dirty = 1'b1; run(3'b100, 4'd0, "R8 trap ignores exec");
  endtask

  task automatic t_debug();
    base_entry(); kind = 2'd0; trap = 1'b1; dirty = 1'b0;
    run(3'b111, 4'd0, "R10 bits skipped");
    trap = 1'b0; dirty = 1'b1; pen = 1'b1; aid = 18'd5; bank[PIDW +: PIDW] = 19'd11;
    run(3'b101, 4'd0, "R10 pid still trims");
  endtask

  initial begin
    t_reset();
    t_miss();
    t_priv();
    t_types();
    t_rights();
    t_pid();
    t_bits();
    t_debug();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule